// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block derives the oversampling enable for a UART from a fast reference clock. Software-visible registers are outside its scope: it receives a static 16-bit integer divisor (delivered as an upper byte and a lower byte), a 4-bit fractional numerator in sixteenths, and an oversampling mode. From these it produces `tick_o`, a one-cycle enable pulse that a transmitter or receiver uses as its 16X, 8X or 4X sample clock.

The fraction is applied by making some tick periods one reference cycle longer than the integer divisor. A 4-bit accumulator adds the numerator once per period. When it carries, that period gets the extra cycle. Over every run of 16 periods the total length is therefore exactly 16·D + F cycles. For example, with a 24 MHz reference and 16X oversampling, D=1 and F=8 give exactly 1 Mbit/s. D=3, F=4 and D=1, F=10 land within about 0.16% of 460.8 kbit/s and 921.6 kbit/s.

A second output, `bit_stb_o`, divides the tick stream by 16, 8 or 4 according to the mode, to mark bit boundaries. Changing any input field restarts both counters cleanly.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tick_o` and `bit_stb_o` are 0.
- R2: With a stable configuration, tick period k (k=0 for the first period after a restart) lasts D+e_k reference cycles. Here e_k is the carry out of the 4-bit sum a_k+F, a_0=0 and a_{k+1}=(a_k+F) mod 16. Any 16 consecutive periods therefore total 16·D+F cycles.
- R3: The integer divisor D is {`div_hi_i`,`div_lo_i`}, with `div_hi_i` in bits 15:8.
- R4: When D=0 the tick output stays 0.
- R5: The fraction is used only in mode 2'b00 (16X). In modes 2'b01 (8X), 2'b10 and 2'b11 (both 4X), F is treated as 0 and every period lasts D cycles.
- R6: A change in any of `div_hi_i`, `div_lo_i`, `div_frac_i` or `mode_i` restarts the divisor.
  - On the cycle after the first clock edge that sees the new values, `tick_o` and `bit_stb_o` are 0.
  - The first tick is observed D+e_0 cycles after that edge.
- R7: `tick_o` is high for one cycle per period. For D≥2 no two consecutive cycles both carry a tick.
- R8: `bit_stb_o` is high on the cycle after the 16th (mode 00), 8th (mode 01) or 4th (modes 10/11) tick since the last restart, and after every further such group. It is low otherwise.
- R9: With D≠0, no more than D+1 cycles pass without a tick after a restart or a previous tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_hi_i | input | 8 | Integer divisor, upper byte |
| div_lo_i | input | 8 | Integer divisor, lower byte |
| div_frac_i | input | 4 | Fractional numerator in sixteenths |
| mode_i | input | 2 | Oversampling mode: 00=16X, 01=8X, 10/11=4X |
| tick_o | output | 1 | One-cycle oversampling enable |
| bit_stb_o | output | 1 | One-cycle bit-boundary strobe |

## Verification
The assertions check every cycle for the following:
- silence while the divisor is zero;
- silence right after a configuration change;
- bit strobes that always follow a tick;
- no back-to-back ticks for D≥2;
- the D+1 ceiling on the gap between ticks.

The exact placement of the long periods within the 16-period pattern is shown only by the bench scenarios. So are the 16·D+F total, the masking of the fraction in 8X and 4X modes, and the 16/8/4 grouping of bit strobes. The bench checks each measured period against a model of the accumulator.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic [1:0] {
    OVS_X16  = 2'b00,
    OVS_X8   = 2'b01,
    OVS_X4   = 2'b10,
    OVS_X4B  = 2'b11
  } ovs_mode_e;

  localparam int BIT_CNT_W = 4;

  function automatic logic [BIT_CNT_W-1:0] ticks_per_bit_m1(input logic [1:0] m);
    case (m)
      2'b00:   return 4'd15;
      2'b01:   return 4'd7;
      default: return 4'd3;
    endcase
  endfunction

  function automatic logic frac_allowed(input logic [1:0] m);
    return (m == OVS_X16);
  endfunction
endpackage

// File: rtl/fbg_cfg_track.sv
module fbg_cfg_track #(
  parameter int HI_W   = 8,
  parameter int LO_W   = 8,
  parameter int FRAC_W = 4,
  localparam int INT_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [LO_W-1:0]   lo_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [1:0]        mode_i,
  output logic              restart_o,
  output logic [INT_W-1:0]  int_q_o,
  output logic [FRAC_W-1:0] frac_eff_o,
  output logic [3:0]        tpb_m1_o,
  output logic              int_zero_o
);
  import fbg_pkg::*;

  logic [HI_W-1:0]   hi_q;
  logic [LO_W-1:0]   lo_q;
  logic [FRAC_W-1:0] frac_q;
  logic [1:0]        mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      frac_q <= '0;
      mode_q <= 2'b00;
    end else begin
      hi_q   <= hi_i;
      lo_q   <= lo_i;
      frac_q <= frac_i;
      mode_q <= mode_i;
    end
  end

  assign restart_o  = (hi_i != hi_q) || (lo_i != lo_q) ||
                      (frac_i != frac_q) || (mode_i != mode_q);
  assign int_q_o    = {hi_q, lo_q};
  assign int_zero_o = (int_q_o == '0);
  assign frac_eff_o = frac_allowed(mode_q) ? frac_q : '0;
  assign tpb_m1_o   = ticks_per_bit_m1(mode_q);
endmodule

// File: rtl/fbg_frac_accum.sv
module fbg_frac_accum #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              advance_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              extra_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
  assign extra_o = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      acc_q <= '0;
    end else if (advance_i) begin
      acc_q <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic [INT_W-1:0] div_i,
  input  logic             extra_i,
  output logic             wrap_o,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt_q;
  logic [INT_W:0]   last;

  assign last   = {1'b0, div_i} - {{INT_W{1'b0}}, 1'b1} + {{INT_W{1'b0}}, extra_i};
  assign wrap_o = !clear_i && ({1'b0, cnt_q} == last);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (wrap_o) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fbg_bit_timer.sv
module fbg_bit_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_m1_i,
  output logic             stb_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
      stb_o <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == limit_m1_i) begin
        cnt_q <= '0;
        stb_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        stb_o <= 1'b0;
      end
    end else begin
      stb_o <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int HI_W   = 8,
  parameter int LO_W   = 8,
  parameter int FRAC_W = 4,
  localparam int INT_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HI_W-1:0]   div_hi_i,
  input  logic [LO_W-1:0]   div_lo_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic [1:0]        mode_i,
  output logic              tick_o,
  output logic              bit_stb_o
);
  logic              restart;
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_eff;
  logic [3:0]        tpb_m1;
  logic              int_zero;
  logic              extra;
  logic              wrap;
  logic              hold;

  fbg_cfg_track #(.HI_W(HI_W), .LO_W(LO_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk(clk), .rst(rst),
    .hi_i(div_hi_i), .lo_i(div_lo_i), .frac_i(div_frac_i), .mode_i(mode_i),
    .restart_o(restart), .int_q_o(int_q), .frac_eff_o(frac_eff),
    .tpb_m1_o(tpb_m1), .int_zero_o(int_zero)
  );

  assign hold = restart || int_zero;

  fbg_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .clear_i(hold), .advance_i(wrap),
    .frac_i(frac_eff), .extra_o(extra)
  );

  fbg_period_cnt #(.INT_W(INT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear_i(hold), .div_i(int_q),
    .extra_i(extra), .wrap_o(wrap), .tick_o(tick_o)
  );

  fbg_bit_timer #(.CNT_W(4)) u_bit (
    .clk(clk), .rst(rst), .restart_i(restart), .tick_i(tick_o),
    .limit_m1_i(tpb_m1), .stb_o(bit_stb_o)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int HI_W   = 8,
  parameter int LO_W   = 8,
  parameter int FRAC_W = 4,
  localparam int INT_W = HI_W + LO_W
) (
  input logic              clk,
  input logic              rst,
  input logic [HI_W-1:0]   div_hi_i,
  input logic [LO_W-1:0]   div_lo_i,
  input logic [FRAC_W-1:0] div_frac_i,
  input logic [1:0]        mode_i,
  input logic              tick_o,
  input logic              bit_stb_o
);
  logic [INT_W+FRAC_W+1:0] cfg_now, cfg_prev;
  logic [INT_W-1:0]        div_prev;
  logic [INT_W+1:0]        gap_q;
  logic                    changed;

  assign cfg_now = {div_hi_i, div_lo_i, div_frac_i, mode_i};
  assign changed = (cfg_now != cfg_prev);
  assign div_prev = cfg_prev[INT_W+FRAC_W+1:FRAC_W+2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_prev <= '0;
      gap_q    <= '0;
    end else begin
      cfg_prev <= cfg_now;
      if (changed || tick_o) gap_q <= '0;
      else if (gap_q != '1)  gap_q <= gap_q + 1'b1;
    end
  end

  assert_no_tick_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (div_prev == '0) |-> !tick_o);

  assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    changed |=> (!tick_o && !bit_stb_o));

  assert_stb_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
    bit_stb_o |-> $past(tick_o));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !changed && div_prev >= 2) |=> !tick_o);

  assert_gap_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (!changed && div_prev != '0) |-> (gap_q <= {2'b00, div_prev} + 1));
endmodule

bind frac_baud_gen fbg_checker #(.HI_W(HI_W), .LO_W(LO_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .div_hi_i(div_hi_i), .div_lo_i(div_lo_i),
  .div_frac_i(div_frac_i), .mode_i(mode_i), .tick_o(tick_o), .bit_stb_o(bit_stb_o)
);

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] hi = 8'd0, lo = 8'd0;
  logic [3:0] fr = 4'd0;
  logic [1:0] md = 2'd0;
  logic       tick, bit_stb;
  int         checks = 0, errors = 0;
  bit         finished = 0;

  frac_baud_gen dut (
    .clk(clk), .rst(rst), .div_hi_i(hi), .div_lo_i(lo), .div_frac_i(fr),
    .mode_i(md), .tick_o(tick), .bit_stb_o(bit_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int f_eff(input int f, input int m);
    return (m == 0) ? f : 0;
  endfunction

  function automatic int ticks_per_bit(input int m);
    return (m == 0) ? 16 : (m == 1) ? 8 : 4;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int h, input int l, input int f, input int m);
    @(negedge clk);
    hi = h[7:0]; lo = l[7:0]; fr = f[3:0]; md = m[1:0];
    @(posedge clk); #1;
    check(!tick && !bit_stb, "R6 quiet after change", {30'd0, tick, bit_stb}, 0);
  endtask

  // run n periods after apply(); checks R2/R3/R5/R6 periods and R8 strobes
  task automatic run(input int n, input string tag);
    int d, f, nb, acc, tc, sum16;
    bit exp_stb, stb_bad;
    d = {hi, lo};
    f = f_eff(fr, md);
    nb = ticks_per_bit(md);
    acc = 0; tc = 0; sum16 = 0; exp_stb = 0; stb_bad = 0;
    if (d == 0) begin
      bit seen = 0;
      for (int c = 0; c < 300; c++) begin
        @(posedge clk); #1;
        if (tick || bit_stb) seen = 1;
      end
      check(!seen, "R4 no tick with zero divisor", seen, 0);
      return;
    end
    for (int i = 0; i < n; i++) begin
      int c, exp_len;
      exp_len = d + (((acc + f) >= 16) ? 1 : 0);
      c = 0;
      do begin
        @(posedge clk); #1;
        c++;
        if (bit_stb != exp_stb) stb_bad = 1;
        exp_stb = 0;
      end while (!tick && c <= d + 2);
      check(c == exp_len, tag, c, exp_len);
      if (i < 16) sum16 += c;
      acc = (acc + f) % 16;
      tc++;
      exp_stb = (tc % nb) == 0;
    end
    @(posedge clk); #1;
    if (bit_stb != exp_stb) stb_bad = 1;
    check(!stb_bad, "R8 bit strobe grouping", stb_bad, 0);
    if (n >= 16) check(sum16 == 16*d + f, "R2 sixteen-period total", sum16, 16*d + f);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    hi = 8'd0; lo = 8'd5; fr = 4'd3; md = 2'd0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check(!tick && !bit_stb, "R1 reset outputs", {30'd0, tick, bit_stb}, 0);
    end
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(!tick && !bit_stb, "R1 first cycle after reset", {30'd0, tick, bit_stb}, 0);

    apply(0, 1, 8, 0);  run(32, "R2 D=1 F=8 period");
    apply(0, 3, 4, 0);  run(32, "R2 D=3 F=4 period");
    apply(0, 1, 10, 0); run(32, "R2 D=1 F=10 period");
    apply(0, 2, 0, 0);  run(20, "R2 D=2 F=0 period");
    apply(0, 3, 0, 0);  run(20, "R2 D=3 F=0 period");
    apply(0, 1, 0, 0);  run(20, "R7 D=1 every-cycle tick");
    apply(0, 0, 9, 0);  run(1, "R4");
    apply(0, 5, 9, 1);  run(20, "R5 8X ignores fraction");
    apply(0, 4, 15, 2); run(20, "R5 4X ignores fraction");
    apply(0, 6, 7, 3);  run(20, "R5 mode 11 ignores fraction");
    apply(1, 44, 3, 0); run(16, "R3 upper byte weight D=300");
    apply(0, 50, 7, 0); run(1, "R6 before restart");
    for (int k = 0; k < 20; k++) @(posedge clk);
    apply(0, 7, 11, 0); run(24, "R6 restart mid-period");
    apply(0, 7, 12, 0); run(24, "R6 fraction-only change");
    for (int r = 0; r < 12; r++) begin
      apply(0, 1 + ($urandom % 40), $urandom % 16, $urandom % 4);
      run(20, "R2 random config period");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule